// File: doc/BRIEF.md
# Shape Edge Sequencer

This block sits between a drawing-command queue and a pair of line generators. It keeps four vertex registers that a host loads with 16-bit words. When a drawing command is taken from the queue, the block picks a per-shape list of stages. Each stage names, separately for X and for Y, the vertex that supplies each endpoint of one edge. The block then walks the two edge generators through their lists, advancing each one on that generator's own completion pulse.

The first edge generator works through outlines: pixels, lines, boxes and quadrilaterals. Triangles use both generators. The first one draws the long side from vertex 0 to vertex 2, while the second one draws the two short sides in turn. This keeps the two generators aligned row by row: the second generator waits for the first Y stop of the first generator, and each generator's stop is released only when the other generator newly reaches a row boundary. A busy flag holds off further commands while any stage is pending or while an external span generator is still working.

Top module: `shapeEdgeSeq`

## Requirements
- R1: A command is taken (`cmdTake` high in the same cycle) only when `cmdValid` is high, `busy` is low, `cmdByte[7:5]` is zero and `cmdByte[2:0]` is nonzero. `cmdByte[3]` is the fill bit, and `cmdByte[3:0]` is the shape code: 1 pixel, 2 line, 3 triangle, 4 box, 5 quadrilateral, 6 ellipse, 7 curve.
- R2: `busy` is combinational. It is high whenever either sequence counter is below its end value, or whenever `spanBusy` is high.
- R3: A vertex write with word bits [15:12] equal to 8h to Bh loads X[0] to X[3], and 9h is X[1]. Bits [15:12] equal to Ch to Fh load Y[0] to Y[3]. The value comes from the low bits of the word. Words whose bit 15 is 0 change no vertex.
- R4: The stage counts for edge-1/edge-2 are: pixel 1/0, line 1/0, triangle 1/2, box 4/0, quadrilateral 4/0. Every other code, and every filled code, has 0/0, so such a command is taken but never raises `busy`.
- R5: A selection is packed as {A.x, A.y, B.x, B.y}, 2 bits each with A.x in the top bits. Endpoint coordinates are packed the same way, each field being the selected vertex value. A pixel uses vertex 0 for both ends. A line runs from vertex 0 to vertex 1.
- R6: For a triangle, edge-1 runs from vertex 0 to vertex 2 in a single stage. Edge-2 runs from 0 to 1, then from 1 to 2.
- R7: A box visits the corners (x0,y0), (x1,y0), (x1,y1), (x0,y1) and closes back to (x0,y0), one corner pair per stage.
- R8: A quadrilateral visits the edges 0→1, 1→2, 2→3 and 3→0.
- R9: A completion pulse advances its generator's counter and loads the next selection one cycle later, but only while that counter is below its end. A completion pulse at the end value changes nothing.
- R10: `edge1Run` is high while edge-1 has stages pending, and low during its completion pulse.
- R11: `edge2Run` stays low until edge-1 first reports a Y stop after the command. From that cycle on it is high while edge-2 has stages pending, except during its completion pulse.
- R12: `edge1StopEn` is low in a cycle where `edge2YStop` rises, and is also low when edge-2 has no stage pending. `edge2StopEn` mirrors this using `edge1YStop` and edge-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Queue holds a command |
| cmdByte | input | 8 | Command at the head of the queue |
| vtxWe | input | 1 | Vertex word strobe |
| vtxWord | input | 16 | Vertex select nibble plus value |
| edge1Done | input | 1 | Edge-1 completion pulse |
| edge2Done | input | 1 | Edge-2 completion pulse |
| edge1YStop | input | 1 | Edge-1 halted at a row boundary |
| edge2YStop | input | 1 | Edge-2 halted at a row boundary |
| spanBusy | input | 1 | Span generator still working |
| cmdTake | output | 1 | Command accepted this cycle (queue pop) |
| busy | output | 1 | Shape in progress |
| edge1Run | output | 1 | Run control for edge-1 |
| edge2Run | output | 1 | Run control for edge-2 |
| edge1StopEn | output | 1 | Stop enable for edge-1 |
| edge2StopEn | output | 1 | Stop enable for edge-2 |
| edge1Sel | output | 8 | Edge-1 vertex indices {Ax,Ay,Bx,By} |
| edge2Sel | output | 8 | Edge-2 vertex indices {Ax,Ay,Bx,By} |
| edge1Pts | output | 4*CW | Edge-1 endpoint values {Ax,Ay,Bx,By} |
| edge2Pts | output | 4*CW | Edge-2 endpoint values {Ax,Ay,Bx,By} |

## Verification
The bench builds the block with the default 12-bit coordinate width. It loads all eight vertex registers with distinct values, so every X or Y field that is fed from a wrong vertex shows up at once. It sweeps every shape code, both the outline and the filled forms, and checks each stage's selection and endpoint values against lists it derives by formula. It also toggles the Y-stop inputs around a triangle so that the handoff between edges, the rising-edge stop release and the span hold-off are all observed at the ports.

// File: rtl/shapeSeqPkg.sv
package shapeSeqPkg;
  localparam int STG_W = 3;

  typedef struct packed {
    logic [1:0] ax;
    logic [1:0] ay;
    logic [1:0] bx;
    logic [1:0] by;
  } vtxSel_t;

  typedef struct packed {
    logic             ld1;
    logic             ld2;
    logic [3:0]       shape;
    logic [STG_W-1:0] st1;
    logic [STG_W-1:0] st2;
  } seqStrobe_t;

  // Stage count per generator; filled codes (bit 3 set) get none.
  function automatic logic [STG_W-1:0] stageCount(input logic gen2, input logic [3:0] shape);
    case (shape)
      4'd1, 4'd2: return gen2 ? 3'd0 : 3'd1;
      4'd3:       return gen2 ? 3'd2 : 3'd1;
      4'd4, 4'd5: return gen2 ? 3'd0 : 3'd4;
      default:    return 3'd0;
    endcase
  endfunction

  function automatic vtxSel_t stageSel(input logic gen2, input logic [3:0] shape,
                                       input logic [STG_W-1:0] stg);
    vtxSel_t s;
    s = '0;
    if (stg < stageCount(gen2, shape)) begin
      case (shape)
        4'd2: begin s.bx = 2'd1; s.by = 2'd1; end
        4'd3: begin
          if (!gen2) begin
            s.bx = 2'd2; s.by = 2'd2;
          end else begin
            s.ax = stg[1:0]; s.ay = stg[1:0];
            s.bx = stg[1:0] + 2'd1; s.by = stg[1:0] + 2'd1;
          end
        end
        4'd4: begin
          case (stg[1:0])
            2'd0: begin s.ax = 2'd0; s.ay = 2'd0; s.bx = 2'd1; s.by = 2'd0; end
            2'd1: begin s.ax = 2'd1; s.ay = 2'd0; s.bx = 2'd1; s.by = 2'd1; end
            2'd2: begin s.ax = 2'd1; s.ay = 2'd1; s.bx = 2'd0; s.by = 2'd1; end
            default: begin s.ax = 2'd0; s.ay = 2'd1; s.bx = 2'd0; s.by = 2'd0; end
          endcase
        end
        4'd5: begin
          s.ax = stg[1:0]; s.ay = stg[1:0];
          s.bx = stg[1:0] + 2'd1; s.by = stg[1:0] + 2'd1;
        end
        default: s = '0;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/shapeSeqCtrl.sv
module shapeSeqCtrl
  import shapeSeqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  input  logic [7:0] cmdByte,
  input  logic       edge1Done,
  input  logic       edge2Done,
  input  logic       edge1YStop,
  input  logic       edge2YStop,
  input  logic       spanBusy,
  output logic       cmdTake,
  output logic       busy,
  output logic       edge1Run,
  output logic       edge2Run,
  output logic       edge1StopEn,
  output logic       edge2StopEn,
  output seqStrobe_t strobe
);
  logic [STG_W-1:0] seq1, seq2, end1, end2;
  logic [3:0]       shapeReg;
  logic             edge2Started, prevY1, prevY2;
  logic             active1, active2, adv1, adv2, rise1, rise2;

  always_comb begin
    active1 = seq1 != end1;
    active2 = seq2 != end2;
    busy    = active1 || active2 || spanBusy;
    cmdTake = cmdValid && !busy && (cmdByte[7:5] == 3'd0) && (cmdByte[2:0] != 3'd0);
    adv1    = edge1Done && active1;
    adv2    = edge2Done && active2;
    rise1   = edge1YStop && !prevY1;
    rise2   = edge2YStop && !prevY2;

    edge1Run    = active1 && !edge1Done;
    edge2Run    = active2 && (edge2Started || edge1YStop) && !edge2Done;
    edge1StopEn = active2 && !rise2;
    edge2StopEn = active1 && !rise1;

    strobe.ld1   = cmdTake || adv1;
    strobe.ld2   = cmdTake || adv2;
    strobe.shape = cmdTake ? cmdByte[3:0] : shapeReg;
    strobe.st1   = cmdTake ? '0 : seq1 + 3'd1;
    strobe.st2   = cmdTake ? '0 : seq2 + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq1 <= '0; seq2 <= '0; end1 <= '0; end2 <= '0;
      shapeReg <= '0; edge2Started <= 1'b0;
      prevY1 <= 1'b0; prevY2 <= 1'b0;
    end else begin
      prevY1 <= edge1YStop;
      prevY2 <= edge2YStop;
      if (cmdTake) begin
        shapeReg     <= cmdByte[3:0];
        end1         <= stageCount(1'b0, cmdByte[3:0]);
        end2         <= stageCount(1'b1, cmdByte[3:0]);
        seq1         <= '0;
        seq2         <= '0;
        edge2Started <= 1'b0;
      end else begin
        if (adv1) seq1 <= seq1 + 3'd1;
        if (adv2) seq2 <= seq2 + 3'd1;
        if (active2 && edge1YStop) edge2Started <= 1'b1;
      end
    end
  end

  // R9: counters never pass their end value
  assert_seq_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (seq1 <= end1) && (seq2 <= end2));
  // R9: a completion pulse while pending moves the counter by one
  assert_advance_R9: assert property (@(posedge clk) disable iff (rst)
    (edge1Done && active1 && !cmdTake) |=> (seq1 == $past(seq1) + 3'd1));
  // R9: without a pulse or a new command the counter holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!edge2Done && !cmdTake) |=> $stable(seq2));
  // R11: edge-2 runs only once edge-1 has reported a Y stop
  assert_edge2_gate_R11: assert property (@(posedge clk) disable iff (rst)
    cmdTake |=> (!edge2Run || edge1YStop));
endmodule

// File: rtl/shapeSeqData.sv
module shapeSeqData
  import shapeSeqPkg::*;
#(
  parameter int CW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vtxWe,
  input  logic [15:0]     vtxWord,
  input  seqStrobe_t      strobe,
  output logic [7:0]      edge1Sel,
  output logic [7:0]      edge2Sel,
  output logic [4*CW-1:0] edge1Pts,
  output logic [4*CW-1:0] edge2Pts
);
  localparam int NV = 4;

  logic [CW-1:0] xReg [NV];
  logic [CW-1:0] yReg [NV];
  vtxSel_t       sel1, sel2;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NV; i++) begin
        xReg[i] <= '0;
        yReg[i] <= '0;
      end
    end else if (vtxWe && vtxWord[15]) begin
      if (vtxWord[14]) yReg[vtxWord[13:12]] <= vtxWord[CW-1:0];
      else             xReg[vtxWord[13:12]] <= vtxWord[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel1 <= '0;
      sel2 <= '0;
    end else begin
      if (strobe.ld1) sel1 <= stageSel(1'b0, strobe.shape, strobe.st1);
      if (strobe.ld2) sel2 <= stageSel(1'b1, strobe.shape, strobe.st2);
    end
  end

  always_comb begin
    edge1Sel = sel1;
    edge2Sel = sel2;
    edge1Pts = {xReg[sel1.ax], yReg[sel1.ay], xReg[sel1.bx], yReg[sel1.by]};
    edge2Pts = {xReg[sel2.ax], yReg[sel2.ay], xReg[sel2.bx], yReg[sel2.by]};
  end

  // R9: a selection only changes on a load strobe
  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !strobe.ld1 |=> $stable(sel1));

  for (genvar g = 0; g < NV; g++) begin : gVtxChk
    // R3: words with bit 15 clear leave every vertex untouched
    assert_vtx_ignore_R3: assert property (@(posedge clk) disable iff (rst)
      (!vtxWe || !vtxWord[15]) |=> ($stable(xReg[g]) && $stable(yReg[g])));
  end
endmodule

// File: rtl/shapeEdgeSeq.sv
module shapeEdgeSeq
  import shapeSeqPkg::*;
#(
  parameter int CW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmdValid,
  input  logic [7:0]      cmdByte,
  input  logic            vtxWe,
  input  logic [15:0]     vtxWord,
  input  logic            edge1Done,
  input  logic            edge2Done,
  input  logic            edge1YStop,
  input  logic            edge2YStop,
  input  logic            spanBusy,
  output logic            cmdTake,
  output logic            busy,
  output logic            edge1Run,
  output logic            edge2Run,
  output logic            edge1StopEn,
  output logic            edge2StopEn,
  output logic [7:0]      edge1Sel,
  output logic [7:0]      edge2Sel,
  output logic [4*CW-1:0] edge1Pts,
  output logic [4*CW-1:0] edge2Pts
);
  seqStrobe_t strobe;

  shapeSeqCtrl ctrl_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .edge1Done(edge1Done), .edge2Done(edge2Done),
    .edge1YStop(edge1YStop), .edge2YStop(edge2YStop), .spanBusy(spanBusy),
    .cmdTake(cmdTake), .busy(busy), .edge1Run(edge1Run), .edge2Run(edge2Run),
    .edge1StopEn(edge1StopEn), .edge2StopEn(edge2StopEn), .strobe(strobe)
  );

  shapeSeqData #(.CW(CW)) data_i (
    .clk(clk), .rst(rst), .vtxWe(vtxWe), .vtxWord(vtxWord), .strobe(strobe),
    .edge1Sel(edge1Sel), .edge2Sel(edge2Sel), .edge1Pts(edge1Pts), .edge2Pts(edge2Pts)
  );
endmodule

// File: tb/shapeEdgeSeq_tb_top.sv
module shapeEdgeSeq_tb_top;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 1'b0, vtxWe = 1'b0;
  logic [7:0] cmdByte = '0;
  logic [15:0] vtxWord = '0;
  logic edge1Done = 1'b0, edge2Done = 1'b0, edge1YStop = 1'b0, edge2YStop = 1'b0, spanBusy = 1'b0;
  logic cmdTake, busy, edge1Run, edge2Run, edge1StopEn, edge2StopEn;
  logic [7:0] edge1Sel, edge2Sel;
  logic [4*CW-1:0] edge1Pts, edge2Pts;

  int nChecks = 0, nFail = 0;
  logic [CW-1:0] vx [4];
  logic [CW-1:0] vy [4];

  always #5 clk = ~clk;

  shapeEdgeSeq #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdByte(cmdByte), .vtxWe(vtxWe),
    .vtxWord(vtxWord), .edge1Done(edge1Done), .edge2Done(edge2Done),
    .edge1YStop(edge1YStop), .edge2YStop(edge2YStop), .spanBusy(spanBusy),
    .cmdTake(cmdTake), .busy(busy), .edge1Run(edge1Run), .edge2Run(edge2Run),
    .edge1StopEn(edge1StopEn), .edge2StopEn(edge2StopEn), .edge1Sel(edge1Sel),
    .edge2Sel(edge2Sel), .edge1Pts(edge1Pts), .edge2Pts(edge2Pts)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int expCnt(input bit g2, input int sh);
    case (sh)
      1, 2: return g2 ? 0 : 1;
      3:    return g2 ? 2 : 1;
      4, 5: return g2 ? 0 : 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] expSel(input bit g2, input int sh, input int s);
    int ax = 0, ay = 0, bx = 0, by = 0;
    int k = (s + 1) % 4;
    case (sh)
      2: begin bx = 1; by = 1; end
      3: if (g2) begin ax = s; ay = s; bx = s + 1; by = s + 1; end
         else begin bx = 2; by = 2; end
      4: begin
        ax = (s == 1 || s == 2); ay = (s >= 2);
        bx = (k == 1 || k == 2); by = (k >= 2);
      end
      5: begin ax = s; ay = s; bx = k; by = k; end
      default: ;
    endcase
    return {ax[1:0], ay[1:0], bx[1:0], by[1:0]};
  endfunction

  function automatic logic [4*CW-1:0] expPts(input logic [7:0] s);
    return {vx[s[7:6]], vy[s[5:4]], vx[s[3:2]], vy[s[1:0]]};
  endfunction

  task automatic wrVtx(input logic [3:0] nib, input logic [11:0] val);
    @(negedge clk);
    vtxWe = 1'b1; vtxWord = {nib, val};
    @(negedge clk);
    vtxWe = 1'b0;
  endtask

  task automatic issue(input logic [7:0] cmd);
    @(negedge clk);
    cmdValid = 1'b1; cmdByte = cmd;
    #1 chk("R1 accept", {63'd0, cmdTake}, 64'd1);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic runShape(input logic [7:0] cmd);
    int sh = (cmd[3]) ? 8 : int'(cmd[2:0]);
    int c1 = expCnt(1'b0, sh), c2 = expCnt(1'b1, sh);
    issue(cmd);
    #1 chk("R4 busy after take", {63'd0, busy}, {63'd0, (c1 + c2) != 0});
    for (int s = 0; s < c1; s++) begin
      chk("R5 R6 R7 R8 edge1 sel", {56'd0, edge1Sel}, {56'd0, expSel(1'b0, sh, s)});
      chk("R3 R5 edge1 pts", {16'd0, edge1Pts}, {16'd0, expPts(expSel(1'b0, sh, s))});
      chk("R10 edge1 run", {63'd0, edge1Run}, 64'd1);
      edge1Done = 1'b1;
      #1 chk("R10 run low in pulse", {63'd0, edge1Run}, 64'd0);
      @(negedge clk);
      edge1Done = 1'b0;
      #1;
    end
    chk("R10 edge1 run idle", {63'd0, edge1Run}, 64'd0);
    if (c2 != 0) begin
      chk("R11 edge2 waits", {63'd0, edge2Run}, 64'd0);
      edge1YStop = 1'b1;
      #1 chk("R11 edge2 starts", {63'd0, edge2Run}, 64'd1);
      @(negedge clk);
      edge1YStop = 1'b0;
      #1 chk("R11 edge2 keeps running", {63'd0, edge2Run}, 64'd1);
    end
    for (int s = 0; s < c2; s++) begin
      chk("R6 edge2 sel", {56'd0, edge2Sel}, {56'd0, expSel(1'b1, sh, s)});
      chk("R3 R6 edge2 pts", {16'd0, edge2Pts}, {16'd0, expPts(expSel(1'b1, sh, s))});
      edge2Done = 1'b1;
      @(negedge clk);
      edge2Done = 1'b0;
      #1;
    end
    chk("R2 busy clear at end", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    chk("R2 reset busy", {63'd0, busy}, 64'd0);
    chk("R10 reset run", {62'd0, edge1Run, edge2Run}, 64'd0);
    chk("R5 reset sel", {48'd0, edge1Sel, edge2Sel}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < 4; i++) begin
      vx[i] = 12'h100 + 12'(17 * i + 3);
      vy[i] = 12'h800 + 12'(29 * i + 5);
      wrVtx(4'h8 + 4'(i), vx[i]);
      wrVtx(4'hC + 4'(i), vy[i]);
    end
    wrVtx(4'h1, 12'hFFF);   // R3: ignored
    wrVtx(4'h7, 12'hABC);   // R3: ignored

    // Rejected commands (R1)
    @(negedge clk);
    cmdValid = 1'b1;
    foreach (keep[b]) ; // no-op
    cmdByte = 8'h22; #1 chk("R1 top bits reject", {63'd0, cmdTake}, 64'd0);
    cmdByte = 8'h00; #1 chk("R1 zero reject", {63'd0, cmdTake}, 64'd0);
    cmdByte = 8'h08; #1 chk("R1 fill-only reject", {63'd0, cmdTake}, 64'd0);
    cmdByte = 8'h41; #1 chk("R1 bit6 reject", {63'd0, cmdTake}, 64'd0);
    cmdValid = 1'b0;

    // Sweep every outline and filled code (R4..R8)
    for (int c = 1; c < 16; c++) begin
      if (c[2:0] != 3'd0) runShape(8'(c));
    end

    // R9: completion pulse at end changes nothing
    runShape(8'h02);
    keep = edge1Sel;
    @(negedge clk);
    edge1Done = 1'b1;
    @(negedge clk);
    edge1Done = 1'b0;
    #1 chk("R9 idle pulse sel", {56'd0, edge1Sel}, {56'd0, keep});
    chk("R9 idle pulse busy", {63'd0, busy}, 64'd0);

    // Triangle with stop-release checks (R12, R11)
    issue(8'h03);
    #1 chk("R12 stopEn1 idle", {63'd0, edge1StopEn}, 64'd1);
    chk("R12 stopEn2 idle", {63'd0, edge2StopEn}, 64'd1);
    edge1YStop = 1'b1;
    #1 chk("R12 stopEn2 on rise", {63'd0, edge2StopEn}, 64'd0);
    chk("R11 run on stop", {63'd0, edge2Run}, 64'd1);
    @(negedge clk);
    #1 chk("R12 stopEn2 level held", {63'd0, edge2StopEn}, 64'd1);
    edge1YStop = 1'b0;
    edge2YStop = 1'b1;
    #1 chk("R12 stopEn1 on rise", {63'd0, edge1StopEn}, 64'd0);
    @(negedge clk);
    edge2YStop = 1'b0;
    #1 chk("R12 stopEn1 restored", {63'd0, edge1StopEn}, 64'd1);
    edge1Done = 1'b1;
    @(negedge clk);
    edge1Done = 1'b0;
    #1 chk("R12 stopEn2 edge1 finished", {63'd0, edge2StopEn}, 64'd0);
    chk("R2 busy edge2 pending", {63'd0, busy}, 64'd1);
    edge2Done = 1'b1;
    @(negedge clk);
    edge2Done = 1'b0;
    #1 chk("R6 edge2 second stage", {56'd0, edge2Sel}, {56'd0, expSel(1'b1, 3, 1)});
    edge2Done = 1'b1;
    @(negedge clk);
    edge2Done = 1'b0;
    #1 chk("R12 stopEn1 edge2 finished", {63'd0, edge1StopEn}, 64'd0);

    // Span hold-off (R2, R1)
    spanBusy = 1'b1; cmdValid = 1'b1; cmdByte = 8'h02;
    #1 chk("R2 span busy", {63'd0, busy}, 64'd1);
    chk("R1 no take while busy", {63'd0, cmdTake}, 64'd0);
    @(negedge clk);
    cmdValid = 1'b0; spanBusy = 1'b0;
    #1 chk("R2 span released", {63'd0, busy}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule